// File: doc/BRIEF.md
# Four-Stage In-Order Pipeline with Variable Execute Latency

This block is a scalar, in-order pipeline with four stages: fetch, decode, execute and write-back. Instruction tokens arrive on a valid/ready stream. Each token carries an identifier and a requested execute latency. Fetch, decode and write-back each take one cycle. The execute stage keeps a token for as many cycles as the token asks for.

While execute is still working on a token, fetch and decode keep their current contents and input ready stays low. Write-back receives a bubble in every cycle in which execute does not finish. A stall therefore lasts exactly the extra execute cycles. Completed identifiers leave write-back in program order. A four-bit occupancy vector shows which stages hold a valid token. Data hazards, forwarding and branches are outside this block.

Top module: `mcx_pipeline`

## Requirements
- R1: While reset is active, and until the first token is accepted, `occ` is 0, `wb_valid` is 0 and `in_ready` is 1.
- R2: A token is accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high exactly when execute is empty or is in the last cycle of its current token.
- R3: `occ` bit 0 is fetch, bit 1 is decode, bit 2 is execute and bit 3 is write-back. Take a token accepted on the edge that opens cycle n, with effective latency L. It is in fetch in cycle n and in decode in cycle n+1. It is in execute for cycles n+2 through n+1+L, on consecutive cycles with no gap. In cycle n+2+L, `wb_valid` is high and `wb_id` carries its identifier.
- R4: While execute holds a token that is not in its last cycle, `in_ready` is low and the fetch and decode contents do not change.
- R5: `wb_valid` is low in every cycle that does not directly follow the final execute cycle of some token.
- R6: A latency field of 0 gives an effective latency of 1. A field above MAX_LAT (default 8) gives an effective latency of MAX_LAT. Any other value is used as given.
- R7: Every accepted identifier appears on `wb_id` with `wb_valid` exactly once, in acceptance order.
- R8: Take a one-cycle token accepted right after a four-cycle token. It waits three cycles in decode. Its write-back is in the cycle immediately after the four-cycle token's write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input token present |
| in_ready | output | 1 | Pipeline can take a token this cycle |
| in_id | input | ID_W | Token identifier |
| in_lat | input | LAT_W | Requested execute cycles |
| wb_valid | output | 1 | A token completes write-back this cycle |
| wb_id | output | ID_W | Identifier of the completing token |
| occ | output | 4 | Stage valid flags: bit 0 fetch to bit 3 write-back |

## Verification
A wrong execute counter would show up in the first cycle where `in_ready` or `occ` bit 2 differs from the reference model. That cycle is no later than the token's predicted last execute cycle. A stage register that fails to freeze would show up as a lost, repeated or reordered identifier at write-back. It would also show up as an early write-back, within about three cycles of the stall. A missing bubble would show up at once as `wb_valid` being high in a cycle that the model marks empty.

// File: rtl/mcx_pkg.sv
package mcx_pkg;

  typedef enum logic [1:0] {
    STG_FETCH  = 2'd0,
    STG_DECODE = 2'd1,
    STG_EXEC   = 2'd2,
    STG_WB     = 2'd3
  } stage_e;

  localparam int unsigned NUM_STAGES = 4;
  localparam int unsigned NUM_FRONT  = 2;

  // Map a raw latency request onto the supported window [1, max_lat].
  function automatic int unsigned eff_lat(input int unsigned raw,
                                          input int unsigned max_lat);
    if (raw == 0)            return 1;
    else if (raw > max_lat)  return max_lat;
    else                     return raw;
  endfunction

endpackage

// File: rtl/mcx_rst_sync.sv
module mcx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/mcx_stage_reg.sv
module mcx_stage_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         d_valid,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  output logic [W-1:0] q_data
);
  logic         valid_n;
  logic [W-1:0] data_n;

  always_comb begin
    valid_n = q_valid;
    data_n  = q_data;
    if (en) begin
      valid_n = d_valid;
      data_n  = d_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= valid_n;
      q_data  <= data_n;
    end
  end

  // Contents only move when the stage is enabled (R4).
  assert_stage_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(q_valid) && $stable(q_data)));
endmodule

// File: rtl/mcx_exec.sv
module mcx_exec #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned LAT_W   = 4,
  parameter int unsigned MAX_LAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [ID_W-1:0]  in_id,
  input  logic [LAT_W-1:0] in_lat,
  output logic             advance,
  output logic             done,
  output logic             e_valid,
  output logic [ID_W-1:0]  e_id
);
  import mcx_pkg::*;

  localparam int unsigned CNT_W = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             valid_n;
  logic [ID_W-1:0]  id_n;
  logic [CNT_W-1:0] load_val;

  assign load_val = CNT_W'(eff_lat(32'(in_lat), MAX_LAT));
  assign done     = e_valid && (cnt_q == CNT_W'(1));
  assign advance  = !e_valid || done;

  always_comb begin
    valid_n = e_valid;
    id_n    = e_id;
    cnt_n   = cnt_q;
    if (advance) begin
      valid_n = in_valid;
      id_n    = in_id;
      cnt_n   = in_valid ? load_val : '0;
    end else begin
      cnt_n   = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_valid <= 1'b0;
      e_id    <= '0;
      cnt_q   <= '0;
    end else begin
      e_valid <= valid_n;
      e_id    <= id_n;
      cnt_q   <= cnt_n;
    end
  end

  // Independent run-length counter for the occupancy window check.
  logic [CNT_W:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (e_valid && !advance) run_q <= run_q + 1'b1;
    else                          run_q <= '0;
  end

  assert_exec_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (e_valid && !done) |=> (e_valid && $stable(e_id)));

  assert_lat_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_q < (CNT_W+1)'(MAX_LAT));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!e_valid && in_valid) |=> e_valid);
endmodule

// File: rtl/mcx_wb.sv
module mcx_wb #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            done,
  input  logic [ID_W-1:0] id,
  output logic            wb_valid,
  output logic [ID_W-1:0] wb_id
);
  logic            valid_n;
  logic [ID_W-1:0] id_n;

  always_comb begin
    valid_n = done;
    id_n    = done ? id : wb_id;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
      wb_id    <= '0;
    end else begin
      wb_valid <= valid_n;
      wb_id    <= id_n;
    end
  end

  assert_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !wb_valid);

  assert_wb_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (wb_valid && wb_id == $past(id)));
endmodule

// File: rtl/mcx_pipeline.sv
module mcx_pipeline #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned LAT_W   = 4,
  parameter int unsigned MAX_LAT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [ID_W-1:0]  in_id,
  input  logic [LAT_W-1:0] in_lat,
  output logic             wb_valid,
  output logic [ID_W-1:0]  wb_id,
  output logic [3:0]       occ
);
  import mcx_pkg::*;

  localparam int unsigned TOK_W = ID_W + LAT_W;

  logic rst_n_int;
  logic advance;
  logic done;
  logic e_valid;
  logic [ID_W-1:0] e_id;

  logic             stg_vin  [NUM_FRONT+1];
  logic [TOK_W-1:0] stg_din  [NUM_FRONT+1];

  mcx_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign stg_vin[0] = in_valid;
  assign stg_din[0] = {in_id, in_lat};

  // Fetch (index 0) and decode (index 1) share one frozen-together enable.
  for (genvar g = 0; g < NUM_FRONT; g++) begin : g_front
    mcx_stage_reg #(.W(TOK_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .en      (advance),
      .d_valid (stg_vin[g]),
      .d_data  (stg_din[g]),
      .q_valid (stg_vin[g+1]),
      .q_data  (stg_din[g+1])
    );
  end

  mcx_exec #(.ID_W(ID_W), .LAT_W(LAT_W), .MAX_LAT(MAX_LAT)) u_exec (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .in_valid (stg_vin[NUM_FRONT]),
    .in_id    (stg_din[NUM_FRONT][TOK_W-1:LAT_W]),
    .in_lat   (stg_din[NUM_FRONT][LAT_W-1:0]),
    .advance  (advance),
    .done     (done),
    .e_valid  (e_valid),
    .e_id     (e_id)
  );

  mcx_wb #(.ID_W(ID_W)) u_wb (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .done     (done),
    .id       (e_id),
    .wb_valid (wb_valid),
    .wb_id    (wb_id)
  );

  assign in_ready          = advance;
  assign occ[STG_FETCH]    = stg_vin[1];
  assign occ[STG_DECODE]   = stg_vin[2];
  assign occ[STG_EXEC]     = e_valid;
  assign occ[STG_WB]       = wb_valid;

  // While stalled, no new token may reach fetch and write-back gets a bubble.
  assert_stall_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    !in_ready |=> ($stable(occ[1:0]) && !wb_valid));

  assert_ready_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    !occ[STG_EXEC] |-> in_ready);
endmodule

// File: tb/mcx_pipeline_tb.sv
module mcx_pipeline_tb;
  localparam int ID_W = 8;
  localparam int LAT_W = 4;
  localparam int MAXL = 8;
  localparam int NRAND = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [ID_W-1:0] in_id = '0;
  logic [LAT_W-1:0] in_lat = '0;
  logic in_ready, wb_valid;
  logic [ID_W-1:0] wb_id;
  logic [3:0] occ;

  int checks = 0;
  int fails = 0;
  int tick = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mcx_pipeline #(.ID_W(ID_W), .LAT_W(LAT_W), .MAX_LAT(MAXL)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_id(in_id), .in_lat(in_lat), .wb_valid(wb_valid), .wb_id(wb_id), .occ(occ));

  // Reference state, written from the requirements.
  bit mf_v, md_v, me_v, mw_v;
  logic [ID_W-1:0] mf_id, md_id, me_id, mw_id;
  int mf_l, md_l, mrem;
  int sb_id [0:8191];
  int sb_head = 0, sb_tail = 0;
  int wb_tick [0:255];
  int acc_tick [0:255];

  function automatic int ref_lat(input int raw);
    return (raw < 1) ? 1 : ((raw > MAXL) ? MAXL : raw);
  endfunction

  function automatic bit ref_ready();
    return !me_v || (mrem == 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (tick %0d)", req, act, exp, tick);
    end
  endtask

  task automatic model_step();
    bit rdy, fin;
    rdy = ref_ready();
    fin = me_v && (mrem == 1);
    mw_v = fin;
    if (fin) mw_id = me_id;
    if (rdy) begin
      me_v = md_v; me_id = md_id; mrem = md_v ? ref_lat(md_l) : 0;
      md_v = mf_v; md_id = mf_id; md_l = mf_l;
      mf_v = in_valid; mf_id = in_id; mf_l = int'(in_lat);
      if (in_valid) begin
        sb_id[sb_tail % 8192] = int'(in_id);
        sb_tail++;
        acc_tick[in_id] = tick;
      end
    end else begin
      mrem = mrem - 1;
    end
  endtask

  task automatic compare();
    check(occ == {mw_v, me_v, md_v, mf_v}, "R3/R5 occupancy", int'(occ),
          int'({mw_v, me_v, md_v, mf_v}));
    check(in_ready == ref_ready(), "R2/R4 in_ready", int'(in_ready), int'(ref_ready()));
    check(wb_valid == mw_v, "R5 wb_valid", int'(wb_valid), int'(mw_v));
    if (wb_valid) begin
      wb_tick[wb_id] = tick;
      if (sb_head < sb_tail) begin
        check(int'(wb_id) == sb_id[sb_head % 8192], "R7 order", int'(wb_id),
              sb_id[sb_head % 8192]);
        sb_head++;
      end else begin
        check(1'b0, "R7 duplicate", int'(wb_id), -1);
      end
    end
  endtask

  task automatic step_cycle();
    @(negedge clk);
    tick++;
    model_step();
    compare();
  endtask

  // Hold a token until accepted, then optionally present the next.
  task automatic send(input int id, input int lat);
    in_valid = 1'b1; in_id = ID_W'(id); in_lat = LAT_W'(lat);
    do begin
      step_cycle();
    end while (!(mf_v && mf_id == ID_W'(id) && acc_tick[id] == tick));
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) step_cycle();
  endtask

  initial begin : watchdog
    #(10 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) begin wb_tick[i] = -1; acc_tick[i] = -1; end
    mf_v = 0; md_v = 0; me_v = 0; mw_v = 0; mrem = 0;
    mf_id = '0; md_id = '0; me_id = '0; mw_id = '0; mf_l = 0; md_l = 0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(occ == 4'b0, "R1 occ in reset", int'(occ), 0);
    check(wb_valid == 1'b0, "R1 wb_valid in reset", int'(wb_valid), 0);
    rst_n = 1'b1;
    idle(4);
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);

    // R8: four-cycle token followed by a one-cycle token, back to back
    in_valid = 1'b1; in_id = 8'hA1; in_lat = 4'd4;
    step_cycle();
    in_id = 8'hA2; in_lat = 4'd1;
    step_cycle();
    in_valid = 1'b0;
    idle(12);
    check(wb_tick[8'hA1] == acc_tick[8'hA1] + 6, "R3 long write-back cycle",
          wb_tick[8'hA1] - acc_tick[8'hA1], 6);
    check(wb_tick[8'hA2] == wb_tick[8'hA1] + 1, "R8 follower right after",
          wb_tick[8'hA2] - wb_tick[8'hA1], 1);

    // R6: zero latency acts as one, oversize saturates
    send(8'h10, 0);
    idle(8);
    check(wb_tick[8'h10] - acc_tick[8'h10] == 3, "R6 zero latency",
          wb_tick[8'h10] - acc_tick[8'h10], 3);
    send(8'h11, 15);
    idle(14);
    check(wb_tick[8'h11] - acc_tick[8'h11] == 2 + MAXL, "R6 saturation",
          wb_tick[8'h11] - acc_tick[8'h11], 2 + MAXL);
    send(8'h12, 8);
    idle(14);
    check(wb_tick[8'h12] - acc_tick[8'h12] == 2 + 8, "R3 max latency",
          wb_tick[8'h12] - acc_tick[8'h12], 10);

    // Random mix with held tokens
    begin
      int nid;
      nid = 32;
      for (int c = 0; c < NRAND; c++) begin
        if (!in_valid && ($urandom_range(0, 9) < 7)) begin
          in_valid = 1'b1; in_id = ID_W'(nid); nid = (nid + 1) % 256;
          in_lat = ($urandom_range(0, 3) == 0) ? LAT_W'($urandom_range(0, 15))
                                               : LAT_W'($urandom_range(1, 2));
        end
        begin
          bit took;
          took = in_valid && ref_ready();
          step_cycle();
          if (took) in_valid = 1'b0;
        end
      end
      in_valid = 1'b0;
      idle(40);
    end
    check(sb_head == sb_tail, "R7 nothing dropped", sb_head, sb_tail);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule